// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits in the fetch stage and guesses the next fetch address for every instruction fetched. A direct-mapped table, addressed by the word-index bits of the fetch PC, keeps for each slot a valid flag, the upper PC bits as a tag, and the target that a branch at that address jumped to on its most recent taken execution. When the fetch PC matches a valid slot, the block offers that stored target as the next address, and fetch continues from it speculatively. When it does not match, the block offers the sequential address, which is the PC plus 4.

One cycle after a fetch, the execute side reports how that instruction really left: taken to a given target, or not taken. The block compares this outcome with the address it predicted. If the two differ, it raises a squash in that same cycle, so the instruction fetched from the wrong address is dropped, and it supplies the correct address for fetch to restart from. If they agree, nothing happens and there is no penalty. Every taken outcome writes its tag and target into its slot and overwrites whatever that slot held before.

The fetch and resolve inputs each carry a valid qualifier and have no ready. The block takes both in every cycle and never applies back-pressure. A resolve must arrive exactly one cycle after the fetch it describes. Otherwise the block ignores it.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid, so any fetch gives pred_hit=0 and pred_next_pc=fetch_pc+4. squash is 0 while reset is held.
- R2: With ENTRIES slots and IDX_W=log2(ENTRIES), the slot index is fetch_pc[IDX_W+1:2] (bits 5:2 at the default of 16) and the tag is fetch_pc[PC_W-1:IDX_W+2]. Distinct indices hold independent entries.
- R3: When fetch_valid is 1 and the indexed slot is valid with a matching tag, pred_hit=1 and pred_next_pc is the stored target.
- R4: A valid slot whose tag differs from the fetch PC's tag is a miss: pred_hit=0 and pred_next_pc=fetch_pc+4.
- R5: A resolve (res_valid=1) in the cycle after a fetch defines the actual next address as res_target if res_taken=1, else fetch PC+4. squash=1 with redirect_pc equal to that address when it differs from the prediction, and squash=0 when it matches.
- R6: A taken resolve writes the tag and res_target into the slot and replaces any previous content. A not-taken resolve leaves the table unchanged.
- R7: A fetch predicted taken that resolves not taken squashes and redirects to the fetch PC+4.
- R8: The fetch made in a squash cycle is discarded: a resolve in the next cycle neither squashes nor writes the table.
- R9: A resolve with no fetch in the previous cycle is ignored: no squash and no table write.
- R10: A table write becomes visible to lookups from the following cycle. A lookup in the same cycle as the write sees the old content.
- R11: squash is 0 in any cycle where res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is issued this cycle |
| fetch_pc | input | PC_W | Address being fetched |
| pred_hit | output | 1 | Table hit for this fetch |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| res_valid | input | 1 | Outcome of the previous cycle's fetch is present |
| res_taken | input | 1 | That instruction left by a taken branch |
| res_target | input | PC_W | Taken target of that instruction |
| squash | output | 1 | Drop the fetch made this cycle and redirect |
| redirect_pc | output | PC_W | Correct next address, meaningful while squash=1 |

## Verification
The hardest situations to reach from the ports occur around a squash. The first is a resolve that arrives right after a squash and must be ignored. The second is a lookup of a slot in the very cycle that slot is being rewritten. The stimulus reaches the first by keeping fetch and resolve both active in the cycle after a mispredict, with a resolve target that would squash if it were obeyed. It reaches the second by refetching the mispredicted PC in the squash cycle itself. A further pass fills every slot and then reads each one back, which confirms the index and tag split across all sixteen slots.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned INSN_STEP = 4;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_MATCH = 2'd1,
    RES_MISS  = 2'd2
  } res_kind_e;
endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_target,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = PC_W - IDX_W - 2;

  logic [ENTRIES-1:0] slot_vld;
  logic [TAG_W-1:0]   slot_tag [ENTRIES];
  logic [PC_W-1:0]    slot_tgt [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic             unused_lsbs;

  assign rd_idx      = rd_pc[IDX_W+1:2];
  assign rd_tag      = rd_pc[PC_W-1:IDX_W+2];
  assign wr_idx      = wr_pc[IDX_W+1:2];
  assign wr_tag      = wr_pc[PC_W-1:IDX_W+2];
  assign unused_lsbs = ^{rd_pc[1:0], wr_pc[1:0]};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic [PC_W-1:0]  d_q;
    logic             we;

    assign we = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  v_q <= 1'b0;
      else if (we) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we) begin
        t_q <= wr_tag;
        d_q <= wr_target;
      end
    end

    assign slot_vld[e] = v_q;
    assign slot_tag[e] = t_q;
    assign slot_tgt[e] = d_q;
  end

  assign rd_hit    = slot_vld[rd_idx] && (slot_tag[rd_idx] == rd_tag);
  assign rd_target = slot_tgt[rd_idx];
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic [PC_W-1:0] pred_next_pc,
  input  logic            res_valid,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  output logic            squash,
  output logic [PC_W-1:0] redirect_pc,
  output logic            wr_en,
  output logic [PC_W-1:0] wr_pc,
  output logic [PC_W-1:0] wr_target
);
  logic            pend_v_q;
  logic [PC_W-1:0] pend_pc_q;
  logic [PC_W-1:0] pend_pred_q;
  logic [PC_W-1:0] actual_pc;
  logic            live;
  res_kind_e       kind;

  assign live      = res_valid && pend_v_q;
  assign actual_pc = res_taken ? res_target : pend_pc_q + PC_W'(INSN_STEP);

  always_comb begin
    if (!live)                       kind = RES_NONE;
    else if (actual_pc == pend_pred_q) kind = RES_MATCH;
    else                             kind = RES_MISS;
  end

  assign squash      = (kind == RES_MISS);
  assign redirect_pc = actual_pc;
  assign wr_en       = live && res_taken;
  assign wr_pc       = pend_pc_q;
  assign wr_target   = res_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_v_q <= 1'b0;
    else        pend_v_q <= fetch_valid && !squash;
  end

  always_ff @(posedge clk) begin
    if (fetch_valid) begin
      pend_pc_q   <= fetch_pc;
      pend_pred_q <= pred_next_pc;
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            res_valid,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  output logic            squash,
  output logic [PC_W-1:0] redirect_pc
);
  logic            lk_hit;
  logic [PC_W-1:0] lk_target;
  logic            wr_en;
  logic [PC_W-1:0] wr_pc;
  logic [PC_W-1:0] wr_target;

  btb_table #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pc     (fetch_pc),
    .rd_hit    (lk_hit),
    .rd_target (lk_target),
    .wr_en     (wr_en),
    .wr_pc     (wr_pc),
    .wr_target (wr_target)
  );

  assign pred_hit     = fetch_valid && lk_hit;
  assign pred_next_pc = pred_hit ? lk_target : fetch_pc + PC_W'(INSN_STEP);

  btb_resolve #(.PC_W(PC_W)) u_resolve (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .fetch_pc     (fetch_pc),
    .pred_next_pc (pred_next_pc),
    .res_valid    (res_valid),
    .res_taken    (res_taken),
    .res_target   (res_target),
    .squash       (squash),
    .redirect_pc  (redirect_pc),
    .wr_en        (wr_en),
    .wr_pc        (wr_pc),
    .wr_target    (wr_target)
  );
endmodule

// File: rtl/btb_sva.sv
module btb_sva #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_hit,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            res_valid,
  input logic            res_taken,
  input logic [PC_W-1:0] res_target,
  input logic            squash,
  input logic [PC_W-1:0] redirect_pc
);
  AST_SQUASH_NEEDS_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> res_valid); // R11
  AST_MISS_GOES_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !pred_hit) |-> pred_next_pc == fetch_pc + PC_W'(4)); // R4
  AST_TAKEN_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && res_taken) |-> redirect_pc == res_target); // R5
  AST_NOT_TAKEN_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && !res_taken) |-> redirect_pc == $past(fetch_pc) + PC_W'(4)); // R7
  AST_NO_BACK_TO_BACK_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !squash); // R8
  AST_NO_FETCH_NO_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fetch_valid) |-> !squash); // R9
endmodule

bind btb_predictor btb_sva #(.PC_W(PC_W)) u_btb_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_valid  (fetch_valid),
  .fetch_pc     (fetch_pc),
  .pred_hit     (pred_hit),
  .pred_next_pc (pred_next_pc),
  .res_valid    (res_valid),
  .res_taken    (res_taken),
  .res_target   (res_target),
  .squash       (squash),
  .redirect_pc  (redirect_pc)
);

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;
  localparam int PC_W = 32;
  localparam int N    = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fetch_valid = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_hit;
  logic [PC_W-1:0] pred_next_pc;
  logic            res_valid = 1'b0;
  logic            res_taken = 1'b0;
  logic [PC_W-1:0] res_target = '0;
  logic            squash;
  logic [PC_W-1:0] redirect_pc;

  always #4 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .ENTRIES(N)) i_btb_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_next_pc(pred_next_pc), .res_valid(res_valid),
    .res_taken(res_taken), .res_target(res_target), .squash(squash),
    .redirect_pc(redirect_pc)
  );

  typedef struct {
    logic            hit;
    logic [PC_W-1:0] npc;
    logic            sq;
    logic [PC_W-1:0] rd;
    string           lbl;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference table built from the requirements
  logic            m_v   [N];
  logic [PC_W-1:0] m_tag [N];
  logic [PC_W-1:0] m_tgt [N];
  logic            p_v = 1'b0;
  logic [PC_W-1:0] p_pc, p_pred;

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'((pc >> 2) % N);
  endfunction

  task automatic step(input bit fv, input logic [PC_W-1:0] fpc, input bit rv,
                      input bit rt, input logic [PC_W-1:0] rtgt, input string lbl);
    exp_t e;
    logic [PC_W-1:0] act;
    int i;
    bit live;
    @(posedge clk); #1;
    fetch_valid = fv; fetch_pc = fpc;
    res_valid = rv; res_taken = rt; res_target = rtgt;
    i = idx_of(fpc);
    e.hit = fv && m_v[i] && (m_tag[i] == (fpc >> 6));
    e.npc = e.hit ? m_tgt[i] : fpc + 4;
    live  = rv && p_v;
    act   = rt ? rtgt : p_pc + 4;
    e.sq  = live && (act != p_pred);
    e.rd  = act;
    e.lbl = lbl;
    q.push_back(e);
    if (live && rt) begin
      m_v[idx_of(p_pc)]   = 1'b1;
      m_tag[idx_of(p_pc)] = p_pc >> 6;
      m_tgt[idx_of(p_pc)] = rtgt;
    end
    p_v = fv && !e.sq;
    if (fv) begin p_pc = fpc; p_pred = e.npc; end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pred_hit !== e.hit || pred_next_pc !== e.npc) begin
        failures++;
        $display("FAIL %s prediction: hit=%0b npc=%h expected hit=%0b npc=%h",
                 e.lbl, pred_hit, pred_next_pc, e.hit, e.npc);
      end
      checks++;
      if (squash !== e.sq || (e.sq && redirect_pc !== e.rd)) begin
        failures++;
        $display("FAIL %s resolve: squash=%0b redirect=%h expected squash=%0b redirect=%h",
                 e.lbl, squash, redirect_pc, e.sq, e.rd);
      end
    end
  end

  initial begin
    for (int k = 0; k < N; k++) m_v[k] = 1'b0;
    fetch_valid = 1'b1; res_valid = 1'b1; res_taken = 1'b1; res_target = 32'h40;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (squash !== 1'b0) begin
      failures++;
      $display("FAIL R1 squash during reset: %0b expected 0", squash);
    end
    rst_n = 1'b1;
    step(1, 32'h100, 0, 0, 0,        "R1");
    step(1, 32'h100, 1, 1, 32'h400,  "R5 R10");
    step(1, 32'h200, 1, 1, 32'h999,  "R8");
    step(1, 32'h100, 0, 0, 0,        "R3 R11");
    step(1, 32'h140, 1, 1, 32'h400,  "R4 R5");
    step(1, 32'h100, 1, 0, 0,        "R5 R6");
    step(1, 32'h500, 1, 0, 0,        "R7");
    step(1, 32'h100, 0, 0, 0,        "R6");
    step(1, 32'h108, 1, 1, 32'h800,  "R6");
    step(0, 32'h0,   1, 1, 32'h123,  "R8");
    step(1, 32'h100, 0, 0, 0,        "R6");
    step(0, 32'h0,   1, 1, 32'h800,  "R5");
    step(1, 32'h140, 1, 1, 32'h600,  "R9");
    step(1, 32'h100, 1, 1, 32'h600,  "R6 R10");
    step(1, 32'h100, 0, 0, 0,        "R4");
    for (int k = 0; k < N; k++) begin
      step(1, 32'h2000 + k*4, 0, 0, 0, "R2");
      step(0, 32'h0, 1, 1, 32'h3000 + k*16, "R2");
    end
    for (int k = 0; k < N; k++) step(1, 32'h2000 + k*4, 0, 0, 0, "R2 R3");
    step(0, 32'h0, 0, 0, 0, "R11");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule